// File: doc/BRIEF.md
# Time Synchronization Event and Interrupt Unit

This block keeps a free-running 64-bit system time and turns three kinds of timing event into one interrupt line. A 32-bit addend is summed into a 32-bit fraction register on every clock. Each carry out of that sum advances the system time by one count, so software sets the tick rate by choosing the addend. Software can also load either half of the time directly, which lets a synchronisation routine step the clock.

The first event source is a comparison against a 64-bit target time. The other two are level inputs, one for a master-side and one for a slave-side auxiliary signal. When an auxiliary input goes high, the unit copies the running time into that input's own snapshot register. Every event sets a sticky bit in an event register, and software clears a bit by writing a one to it. A control register holds one mask bit per event, and the interrupt output is the OR of the pending bits whose masks are set.

All registers sit behind a simple word-wide write strobe and a combinational read port.

Top module: `tsync_evt_unit`

## Requirements
- R1: After reset the event register (offset 0x04) reads 0x2, which means only the target-time pending bit is set. The control register (0x00), the addend (0x08), the system time and the target time all read 0, and `irq_o` is low.
- R2: Bit 1 of the event register becomes set on the clock after the 64-bit unsigned system time is greater than or equal to the 64-bit target time. The bit keeps setting for as long as that holds, so writing a new target first and clearing the bit afterwards leaves it clear when the time is below the new target.
- R3: A write to offset 0x04 clears every event bit (3, 2 or 1) whose data bit is 1 and leaves bits written with 0 unchanged. Bits 31:4 and bit 0 always read 0.
- R4: When a clear and a new event hit the same event bit in the same cycle, the bit ends up set.
- R5: A low-to-high change on `aux_lvl_i[1]` (the master input) copies the system time into the master snapshot at 0x28 (low word) and 0x2C (high word), and sets event bit 3. While the input stays high, the snapshot is not captured again.
- R6: A low-to-high change on `aux_lvl_i[0]` (the slave input) copies the system time into the slave snapshot at 0x20 (low word) and 0x24 (high word), and sets event bit 2. While the input stays high, the snapshot is not captured again.
- R7: `irq_o` is high exactly when some event bit is set and its mask bit in the control register is also set. Mask bit 3 gates event bit 3, mask bit 2 gates event bit 2, and mask bit 1 gates event bit 1.
- R8: On every clock the addend (0x08) is added to a 32-bit fraction. A carry out of that addition advances the system time by one on the same edge. Otherwise the time holds.
- R9: The control register, the addend and the target time (0x18 low word, 0x1C high word) read back the values last written to them. The snapshot registers cannot be written.
- R10: A write to 0x10 (time low word) or 0x14 (time high word) loads that half of the system time with the written data, taking priority over the increment in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address, used for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| aux_lvl_i | input | 2 | Auxiliary level inputs: bit 1 is master, bit 0 is slave |
| irq_o | output | 1 | Shared interrupt request |

## Verification
A fraction register that has drifted shows up on the very next carry. The system time then reads one count off within two cycles when the addend is 0x80000000. An event bit that is wrongly set or stuck is visible in the event register read and, once its mask is set, on `irq_o` in the same cycle. A broken edge detector on an auxiliary input is exposed as soon as the time is changed while the input is held high, because the snapshot then reads back a later value than expected.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int TIME_W = 2 * DATA_W;
  localparam int FRAC_W = 32;
  localparam int N_AUX  = 2;
  localparam int EVT_W  = N_AUX + 1;

  localparam logic [ADDR_W-1:0] RA_CTRL      = 8'h00;
  localparam logic [ADDR_W-1:0] RA_EVT       = 8'h04;
  localparam logic [ADDR_W-1:0] RA_ADDEND    = 8'h08;
  localparam logic [ADDR_W-1:0] RA_TIME_LO   = 8'h10;
  localparam logic [ADDR_W-1:0] RA_TIME_HI   = 8'h14;
  localparam logic [ADDR_W-1:0] RA_TGT_LO    = 8'h18;
  localparam logic [ADDR_W-1:0] RA_TGT_HI    = 8'h1C;
  localparam logic [ADDR_W-1:0] RA_SNAP_BASE = 8'h20;
endpackage

// File: rtl/tsync_time_base.sv
module tsync_time_base #(
  parameter int TIME_W = 64,
  parameter int FRAC_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAC_W-1:0] addend_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic [TIME_W-1:0] time_o
);
  localparam int HI_W = TIME_W - DATA_W;

  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [TIME_W-1:0] time_q, time_d;
  logic              carry;
  logic              time_en;

  always_comb begin
    {carry, frac_d} = {1'b0, frac_q} + {1'b0, addend_i};
    time_d = time_q + {{(TIME_W-1){1'b0}}, carry};
    if (ld_lo_i) time_d[DATA_W-1:0] = ld_data_i;
    if (ld_hi_i) time_d[TIME_W-1:DATA_W] = ld_data_i[HI_W-1:0];
    time_en = carry | ld_lo_i | ld_hi_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frac_q <= '0;
    else        frac_q <= frac_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       time_q <= '0;
    else if (time_en) time_q <= time_d;
  end

  assign time_o = time_q;
endmodule

// File: rtl/tsync_snap_capture.sv
module tsync_snap_capture #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              hit_o,
  output logic [TIME_W-1:0] snap_o
);
  logic              lvl_q;
  logic [TIME_W-1:0] snap_q;

  assign hit_o = lvl_i & ~lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap_q <= '0;
    else if (hit_o) snap_q <= time_i;
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/tsync_event_regs.sv
module tsync_event_regs #(
  parameter int N_AUX = 2,
  localparam int EVT_W = N_AUX + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wen_i,
  input  logic             evt_wen_i,
  input  logic [EVT_W-1:0] wbits_i,
  input  logic             tt_hit_i,
  input  logic [N_AUX-1:0] aux_hit_i,
  output logic [EVT_W-1:0] evt_o,
  output logic [EVT_W-1:0] mask_o,
  output logic             irq_o
);
  logic [EVT_W-1:0] evt_q, evt_d, mask_q, set_vec;
  logic             evt_en;

  always_comb begin
    set_vec = {aux_hit_i, tt_hit_i};
    evt_d   = evt_q;
    if (evt_wen_i) evt_d = evt_q & ~wbits_i;
    evt_d  = evt_d | set_vec;
    evt_en = evt_wen_i | (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      evt_q <= EVT_W'(1);
    else if (evt_en) evt_q <= evt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mask_q <= '0;
    else if (ctrl_wen_i) mask_q <= wbits_i;
  end

  assign evt_o  = evt_q;
  assign mask_o = mask_q;
  assign irq_o  = |(evt_q & mask_q);
endmodule

// File: rtl/tsync_evt_unit.sv
module tsync_evt_unit
  import tsync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_AUX-1:0]  aux_lvl_i,
  output logic              irq_o
);
  logic [TIME_W-1:0] systime_w;
  logic [TIME_W-1:0] target_q, target_d;
  logic [FRAC_W-1:0] addend_q, addend_d;
  logic [TIME_W-1:0] snap_w [N_AUX];
  logic [N_AUX-1:0]  aux_hit_w;
  logic [EVT_W-1:0]  evt_w, mask_w;
  logic              tt_hit_w;
  logic              wr_ctrl, wr_evt, wr_add, wr_tlo, wr_thi, wr_glo, wr_ghi;
  logic              target_en, addend_en;

  always_comb begin
    wr_ctrl = reg_wen && (reg_addr == RA_CTRL);
    wr_evt  = reg_wen && (reg_addr == RA_EVT);
    wr_add  = reg_wen && (reg_addr == RA_ADDEND);
    wr_tlo  = reg_wen && (reg_addr == RA_TIME_LO);
    wr_thi  = reg_wen && (reg_addr == RA_TIME_HI);
    wr_glo  = reg_wen && (reg_addr == RA_TGT_LO);
    wr_ghi  = reg_wen && (reg_addr == RA_TGT_HI);
  end

  tsync_time_base #(.TIME_W(TIME_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .addend_i  (addend_q),
    .ld_lo_i   (wr_tlo),
    .ld_hi_i   (wr_thi),
    .ld_data_i (reg_wdata),
    .time_o    (systime_w)
  );

  always_comb begin
    addend_d  = reg_wdata[FRAC_W-1:0];
    addend_en = wr_add;
    target_d  = target_q;
    if (wr_glo) target_d[DATA_W-1:0]      = reg_wdata;
    if (wr_ghi) target_d[TIME_W-1:DATA_W] = reg_wdata;
    target_en = wr_glo | wr_ghi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addend_q <= '0;
    else if (addend_en) addend_q <= addend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         target_q <= '0;
    else if (target_en) target_q <= target_d;
  end

  assign tt_hit_w = (systime_w >= target_q);

  for (genvar k = 0; k < N_AUX; k++) begin : g_snap
    tsync_snap_capture #(.TIME_W(TIME_W)) u_snap (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (aux_lvl_i[k]),
      .time_i (systime_w),
      .hit_o  (aux_hit_w[k]),
      .snap_o (snap_w[k])
    );
  end

  tsync_event_regs #(.N_AUX(N_AUX)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wen_i (wr_ctrl),
    .evt_wen_i  (wr_evt),
    .wbits_i    (reg_wdata[EVT_W:1]),
    .tt_hit_i   (tt_hit_w),
    .aux_hit_i  (aux_hit_w),
    .evt_o      (evt_w),
    .mask_o     (mask_w),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL:    reg_rdata[EVT_W:1] = mask_w;
      RA_EVT:     reg_rdata[EVT_W:1] = evt_w;
      RA_ADDEND:  reg_rdata[FRAC_W-1:0] = addend_q;
      RA_TIME_LO: reg_rdata = systime_w[DATA_W-1:0];
      RA_TIME_HI: reg_rdata = systime_w[TIME_W-1:DATA_W];
      RA_TGT_LO:  reg_rdata = target_q[DATA_W-1:0];
      RA_TGT_HI:  reg_rdata = target_q[TIME_W-1:DATA_W];
      default: begin
        for (int k = 0; k < N_AUX; k++) begin
          if (reg_addr == RA_SNAP_BASE + ADDR_W'(8 * k))
            reg_rdata = snap_w[k][DATA_W-1:0];
          if (reg_addr == RA_SNAP_BASE + ADDR_W'(8 * k + 4))
            reg_rdata = snap_w[k][TIME_W-1:DATA_W];
        end
      end
    endcase
  end
endmodule

// File: rtl/tsync_evt_chk.sv
module tsync_evt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wen,
  input logic [7:0]  reg_addr,
  input logic [2:0]  wbits,
  input logic [1:0]  aux_lvl_i,
  input logic        irq_o,
  input logic [63:0] systime,
  input logic [63:0] target,
  input logic [2:0]  evt,
  input logic [2:0]  mask,
  input logic [63:0] snap_s,
  input logic [63:0] snap_m
);
  logic [1:0] aux_q;
  logic       rise_m, rise_s, time_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aux_q <= 2'b00;
    else        aux_q <= aux_lvl_i;
  end

  assign rise_m  = aux_lvl_i[1] && !aux_q[1];
  assign rise_s  = aux_lvl_i[0] && !aux_q[0];
  assign time_wr = reg_wen && (reg_addr == 8'h10 || reg_addr == 8'h14);

  AST_TT_PEND_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (systime >= target) |=> evt[0]); // R2
  AST_W1C_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == 8'h04 && wbits[2] && !rise_m) |=> !evt[2]); // R3
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rise_m |=> evt[2]); // R4
  AST_SNAP_M_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_m |=> (snap_m == $past(systime))); // R5
  AST_SNAP_S_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_s |=> $stable(snap_s)); // R6
  AST_SNAP_S_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    rise_s |=> evt[1]); // R6
  AST_IRQ_QUIET_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 3'b000) |-> !irq_o); // R7
  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !time_wr |=> (systime == $past(systime) || systime == $past(systime) + 64'd1)); // R8
endmodule

bind tsync_evt_unit tsync_evt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wen   (reg_wen),
  .reg_addr  (reg_addr),
  .wbits     (reg_wdata[3:1]),
  .aux_lvl_i (aux_lvl_i),
  .irq_o     (irq_o),
  .systime   (systime_w),
  .target    (target_q),
  .evt       (evt_w),
  .mask      (mask_w),
  .snap_s    (snap_w[0]),
  .snap_m    (snap_w[1])
);

// File: tb/tsync_evt_unit_tb_top.sv
module tsync_evt_unit_tb_top;
  import tsync_pkg::*;

  typedef struct {
    logic        is_irq;
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wen;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [1:0]  aux_lvl_i;
  logic        irq_o;

  sb_item_t sb_q[$];
  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  tsync_evt_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .aux_lvl_i (aux_lvl_i),
    .irq_o     (irq_o)
  );

  // monitor: compares one expected item per cycle, away from the edge
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      sb_item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {31'b0, irq_o} : reg_rdata;
      n_vec++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h",
                 it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    reg_wen = 1'b0; reg_addr = a;
    it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    reg_wen = 1'b0;
    it.is_irq = 1'b1; it.addr = 8'hFF; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic set_aux(input logic [1:0] v);
    @(posedge clk); #1;
    aux_lvl_i = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0; aux_lvl_i = 2'b00;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(RA_EVT, 32'h2, "R1 event reset");
    rd(RA_CTRL, 32'h0, "R1 control reset");
    rd(RA_ADDEND, 32'h0, "R1 addend reset");
    rd(RA_TIME_LO, 32'h0, "R1 time reset");
    chk_irq(1'b0, "R1 irq reset");

    wr(RA_EVT, 32'h2);
    rd(RA_EVT, 32'h2, "R2 pending resets while time>=target");

    wr(RA_TGT_HI, 32'h0);
    wr(RA_TGT_LO, 32'd100);
    wr(RA_EVT, 32'h2);
    rd(RA_EVT, 32'h0, "R3 w1c after new target (R2)");
    rd(RA_TGT_LO, 32'd100, "R9 target readback");

    wr(RA_TIME_LO, 32'd150);
    rd(RA_EVT, 32'h2, "R2 match after time load");
    rd(RA_TIME_LO, 32'd150, "R10 time load");

    chk_irq(1'b0, "R7 all masked");
    wr(RA_CTRL, 32'h2);
    chk_irq(1'b1, "R7 target mask");
    wr(RA_CTRL, 32'hC);
    chk_irq(1'b0, "R7 aux masks only");
    rd(RA_CTRL, 32'hC, "R9 control readback");

    set_aux(2'b10);
    wr(RA_TIME_LO, 32'd500);
    rd(RA_SNAP_BASE + 8'h08, 32'd150, "R5 master capture");
    rd(RA_SNAP_BASE + 8'h0C, 32'd0, "R5 master capture high");
    rd(RA_EVT, 32'hA, "R5 master event bit");
    chk_irq(1'b1, "R7 master mask");

    wr(RA_EVT, 32'h8);
    rd(RA_EVT, 32'h2, "R3 clear master bit");
    rd(RA_SNAP_BASE + 8'h08, 32'd150, "R5 no recapture while high");

    set_aux(2'b00);
    set_aux(2'b10);
    rd(RA_SNAP_BASE + 8'h08, 32'd500, "R5 recapture after new rise");
    rd(RA_EVT, 32'hA, "R5 event after new rise");
    wr(RA_EVT, 32'h0);
    rd(RA_EVT, 32'hA, "R3 zero write no effect");
    wr(RA_EVT, 32'hFFFF_FFF1);
    rd(RA_EVT, 32'hA, "R3 reserved bits read zero");

    // clear and slave rise in the same cycle
    @(posedge clk); #1;
    reg_wen = 1'b1; reg_addr = RA_EVT; reg_wdata = 32'h4; aux_lvl_i = 2'b11;
    @(posedge clk); #1;
    reg_wen = 1'b0;
    rd(RA_EVT, 32'hE, "R4 set beats clear");
    rd(RA_SNAP_BASE, 32'd500, "R6 slave capture");
    wr(RA_EVT, 32'h4);
    rd(RA_EVT, 32'hA, "R6 no re-set while high");
    wr(RA_EVT, 32'h8);

    wr(RA_TIME_LO, 32'd1000);
    wr(RA_ADDEND, 32'h8000_0000);
    rd(RA_TIME_LO, 32'd1000, "R8 no carry yet");
    rd(RA_TIME_LO, 32'd1001, "R8 first carry");
    rd(RA_TIME_LO, 32'd1001, "R8 half step");
    rd(RA_TIME_LO, 32'd1002, "R8 second carry");
    wr(RA_ADDEND, 32'h0);
    rd(RA_TIME_LO, 32'd1003, "R8 final carry then hold");
    rd(RA_TIME_LO, 32'd1003, "R8 hold with zero addend");

    wr(RA_TGT_HI, 32'h1);
    wr(RA_EVT, 32'h2);
    rd(RA_EVT, 32'h0, "R2 high word below target");
    wr(RA_TIME_HI, 32'h1);
    rd(RA_EVT, 32'h2, "R2 high word reaches target");
    rd(RA_TIME_HI, 32'h1, "R10 high load");
    rd(RA_TGT_HI, 32'h1, "R9 target high readback");

    @(posedge clk);
    while (sb_q.size() != 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule